// File: doc/BRIEF.md
# Label Equivalence Table Manager

This block holds the label tables for a raster-scan connected component labeler. Each cycle the neighbourhood logic ahead of it gives a command and up to two neighbour labels. The block then returns the provisional label for the current pixel. There are three commands: issue a fresh label for an isolated pixel, resolve a pixel that has one labeled neighbour, or join two neighbour labels that meet at this pixel.

Two tables are kept. The first is a temporary-label table: each provisional label maps to its current representative. A label is resolved through a double lookup through this table. The second is a merge-chain table. The second labeling pass reads it through a dedicated read port. A label counter issues labels from 1 upward. Label 0 always means background. The counter is held at its limit rather than wrapped, and a sticky flag records that the supply of labels ran out. A frame-start pulse restarts the counter. Table entries are rewritten when their label is issued, so no bulk clear is needed.

Top module: `lbl_eq_manager`

## Requirements
- R1: After reset `out_valid`, `out_label` and `overflow` are 0, and the first fresh-label command returns label 1.
- R2: Command encoding: `cmd` 2'b00 = idle, 2'b01 = fresh label, 2'b10 = single neighbour, 2'b11 = join. A fresh-label command returns the counter value one cycle later with `out_valid` high. It writes that value to both tables at that label, and the counter then advances by one.
- R3: When labels 1 to NLAB-1 have all been issued, a fresh-label command returns 0 and writes nothing. It also sets `overflow`, which stays high until frame start or reset.
- R4: A single-neighbour command with label `lab_u` returns T(T(lab_u)) one cycle later and writes neither table. T denotes the temporary-label table.
- R5: A join command with labels `lab_u` and `lab_l` returns T(min(T(lab_u),T(lab_l))) one cycle later.
- R6: A join command overwrites T at max(T(lab_u),T(lab_l)) with min(T(lab_u),T(lab_l)).
- R7: A join command updates the merge-chain table E as follows. Let Lmax be the old T at the max index and Lmin the returned label. Then E(E(Lmax)) and E(lab_u) both take E(Lmin). `em_rd_data` shows E(`em_rd_addr`) combinationally.
- R8: A `frame_start` pulse restarts the counter at 1 and clears `overflow`. A command given in the same cycle is ignored: no output and no table write.
- R9: An idle command gives `out_valid` low one cycle later and changes no table.
- R10: A neighbour label of 0 reads as 0 from both tables, and no write is made to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Restart pulse at the top of a frame |
| cmd | input | 2 | Command (idle, fresh, single, join) |
| lab_u | input | LW | Upper neighbour label |
| lab_l | input | LW | Left neighbour label |
| em_rd_addr | input | LW | Merge-chain table read address |
| em_rd_data | output | LW | Merge-chain table entry at `em_rd_addr` |
| out_valid | output | 1 | Result valid, one cycle after a command |
| out_label | output | LW | Provisional label for the pixel |
| overflow | output | 1 | Sticky label-exhaustion flag |

## Verification
Label results and the overflow flag are registered, so they are due exactly one clock edge after the command. Table writes take effect at that same edge, and the merge-chain read port is combinational. The bench drives on the falling edge and reads the registered results at the next falling edge. It then sets the merge-chain read address and compares that entry a nanosecond later, before the following rising edge. A behavioural model is stepped once per command and compared on every cycle, across directed cases and a long random run.

// File: rtl/lbl_eq_pkg.sv
// Shared command encoding for the label equivalence table manager.
package lbl_eq_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_FRESH = 2'b01,
        CMD_ONE   = 2'b10,
        CMD_JOIN  = 2'b11
    } lbl_cmd_e;
endpackage

// File: rtl/lbl_table.sv
// Register-array label table.
// Read ports are asynchronous and write ports are synchronous.
// Entry 0 has no storage: it reads as 0, and writes to it are dropped.
// When several write ports hit the same address, the higher port index wins.
// Assumes every address is below DEPTH.
module lbl_table #(
    parameter int DEPTH = 64,
    parameter int W     = 6,
    parameter int NRD   = 2,
    parameter int NWR   = 1
) (
    input  logic                     clk,
    input  logic [NRD-1:0][W-1:0]    rd_addr,
    output logic [NRD-1:0][W-1:0]    rd_data,
    input  logic [NWR-1:0]           wr_en,
    input  logic [NWR-1:0][W-1:0]    wr_addr,
    input  logic [NWR-1:0][W-1:0]    wr_data
);
    logic [W-1:0] mem [1:DEPTH-1];

    // Write ports, with the highest port index taking priority.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NWR; p++) begin
            if (wr_en[p] && wr_addr[p] != '0) begin
                mem[wr_addr[p]] <= wr_data[p];
            end
        end
    end

    // One combinational read path per port.
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = (rd_addr[r] == '0) ? '0 : mem[rd_addr[r]];
    end
endmodule

// File: rtl/lbl_alloc.sv
// Label issue counter.
// Issues labels 1 to NLAB-1. It raises a sticky overflow flag instead of wrapping.
// Assumes alloc_req is already gated off while frame_start is high.
module lbl_alloc #(
    parameter int NLAB = 64,
    parameter int LW   = $clog2(NLAB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          alloc_req,
    output logic          grant,
    output logic [LW-1:0] new_label,
    output logic          overflow
);
    localparam int CW = LW + 1;
    localparam logic [CW-1:0] LIMIT = CW'(NLAB);

    logic [CW-1:0] cnt;

    assign grant     = alloc_req && (cnt < LIMIT);
    assign new_label = cnt[LW-1:0];

    // Counter and sticky flag: restart on frame start, advance on each granted request.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            cnt      <= CW'(1);
            overflow <= 1'b0;
        end else if (alloc_req) begin
            if (grant) cnt <= cnt + CW'(1);
            else       overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/lbl_eq_manager.sv
// Label equivalence table manager.
// It keeps a temporary-label table T and a merge-chain table E.
// Each command returns a registered provisional label one cycle later.
// All table reads use the state before the clock edge, and all writes land at that edge.
// Assumes NLAB is a power of two, and that neighbour labels are 0 or already issued.
module lbl_eq_manager
    import lbl_eq_pkg::*;
#(
    parameter int NLAB = 64,
    parameter int LW   = $clog2(NLAB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [1:0]    cmd,
    input  logic [LW-1:0] lab_u,
    input  logic [LW-1:0] lab_l,
    input  logic [LW-1:0] em_rd_addr,
    output logic [LW-1:0] em_rd_data,
    output logic          out_valid,
    output logic [LW-1:0] out_label,
    output logic          overflow
);
    lbl_cmd_e c;
    logic do_fresh, do_one, do_join, grant;
    logic [LW-1:0] new_label;
    logic [LW-1:0] t_u, t_l, t_mn, t_mx, t_res, t_oldmax, e_max, e_min;
    logic [3:0][LW-1:0] tr_addr, tr_data;
    logic [2:0][LW-1:0] er_addr, er_data;
    logic [0:0]         tw_en;
    logic [0:0][LW-1:0] tw_addr, tw_data;
    logic [1:0]         ew_en;
    logic [1:0][LW-1:0] ew_addr, ew_data;

    // Decode the command; a frame-start pulse blocks every command.
    always_comb begin
        c        = lbl_cmd_e'(cmd);
        do_fresh = !frame_start && (c == CMD_FRESH);
        do_one   = !frame_start && (c == CMD_ONE);
        do_join  = !frame_start && (c == CMD_JOIN);
    end

    lbl_alloc #(.NLAB(NLAB), .LW(LW)) i_alloc (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .alloc_req(do_fresh), .grant(grant), .new_label(new_label),
        .overflow(overflow)
    );

    // Temporary-label lookups: first level, ordering, then second level.
    always_comb begin
        tr_addr[0] = lab_u;
        tr_addr[1] = lab_l;
        t_u        = tr_data[0];
        t_l        = tr_data[1];
        t_mn       = (t_u < t_l) ? t_u : t_l;
        t_mx       = (t_u < t_l) ? t_l : t_u;
        tr_addr[2] = do_join ? t_mn : t_u;
        tr_addr[3] = t_mx;
        t_res      = tr_data[2];
        t_oldmax   = tr_data[3];
    end

    // Merge-chain lookups, plus the external read port.
    always_comb begin
        er_addr[0] = t_oldmax;
        er_addr[1] = t_res;
        er_addr[2] = em_rd_addr;
        e_max      = er_data[0];
        e_min      = er_data[1];
        em_rd_data = er_data[2];
    end

    // Table write ports: a fresh label seeds both tables, and a join relinks them.
    always_comb begin
        tw_en[0]   = grant || do_join;
        tw_addr[0] = grant ? new_label : t_mx;
        tw_data[0] = grant ? new_label : t_mn;
        ew_en[0]   = grant || do_join;
        ew_addr[0] = grant ? new_label : e_max;
        ew_data[0] = grant ? new_label : e_min;
        ew_en[1]   = do_join;
        ew_addr[1] = lab_u;
        ew_data[1] = e_min;
    end

    lbl_table #(.DEPTH(NLAB), .W(LW), .NRD(4), .NWR(1)) i_tl (
        .clk(clk), .rd_addr(tr_addr), .rd_data(tr_data),
        .wr_en(tw_en), .wr_addr(tw_addr), .wr_data(tw_data)
    );

    lbl_table #(.DEPTH(NLAB), .W(LW), .NRD(3), .NWR(2)) i_em (
        .clk(clk), .rd_addr(er_addr), .rd_data(er_data),
        .wr_en(ew_en), .wr_addr(ew_addr), .wr_data(ew_data)
    );

    // Result register: the issued label, the resolved label, or 0 after overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_label <= '0;
        end else begin
            out_valid <= do_fresh || do_one || do_join;
            if (do_fresh)              out_label <= grant ? new_label : '0;
            else if (do_one || do_join) out_label <= t_res;
            else                        out_label <= '0;
        end
    end
endmodule

// File: rtl/lbl_eq_manager_chk.sv
// Protocol checker for lbl_eq_manager, attached to it with bind.
// It relates the command inputs to the registered outputs one cycle later.
module lbl_eq_manager_chk #(
    parameter int NLAB = 64,
    parameter int LW   = $clog2(NLAB)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic [1:0]    cmd,
    input logic [LW-1:0] lab_u,
    input logic          out_valid,
    input logic [LW-1:0] out_label,
    input logic          overflow
);
    assert_valid_follows_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && cmd != 2'b00) |=> out_valid);

    assert_idle_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start || cmd == 2'b00) |=> !out_valid);

    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !frame_start) |=> overflow);

    assert_exhausted_gives_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !frame_start && cmd == 2'b01) |=> (out_label == '0));

    assert_frame_clears_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !overflow);

    assert_zero_label_resolves_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && cmd == 2'b10 && lab_u == '0) |=> (out_label == '0));

    assert_overflow_needs_fresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(cmd == 2'b01 && !frame_start));
endmodule

bind lbl_eq_manager lbl_eq_manager_chk #(.NLAB(NLAB), .LW(LW)) i_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cmd(cmd),
    .lab_u(lab_u), .out_valid(out_valid), .out_label(out_label),
    .overflow(overflow)
);

// File: tb/test_lbl_eq_manager.sv
// Bench for lbl_eq_manager: a behavioural model is stepped per command and compared on every clock.
module test_lbl_eq_manager;
    localparam int NLAB = 16;
    localparam int LW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic [1:0]    cmd = 2'b00;
    logic [LW-1:0] lab_u = '0, lab_l = '0, em_rd_addr = '0;
    logic [LW-1:0] em_rd_data, out_label;
    logic          out_valid, overflow;

    int n_checks = 0;
    int n_fail   = 0;
    int m_tl [NLAB];
    int m_em [NLAB];
    int m_cnt = 1;
    bit m_ovf = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    lbl_eq_manager #(.NLAB(NLAB), .LW(LW)) i_lbl_eq_manager (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cmd(cmd),
        .lab_u(lab_u), .lab_l(lab_l), .em_rd_addr(em_rd_addr),
        .em_rd_data(em_rd_data), .out_valid(out_valid),
        .out_label(out_label), .overflow(overflow)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one command at a falling edge, step the model, and compare at the next falling edge.
    task automatic step(input bit fs, input int c, input int lu, input int ll);
        int  ev, el;
        int  tu, tl2, mn, mx, res, oldmax, emx, emn;
        string req;
        frame_start = fs; cmd = 2'(c); lab_u = LW'(lu); lab_l = LW'(ll);
        ev = 0; el = 0; req = "R9";
        if (fs) begin
            req = "R8"; m_cnt = 1; m_ovf = 0;
        end else if (c == 1) begin
            req = "R2"; ev = 1;
            if (m_cnt < NLAB) begin
                el = m_cnt; m_tl[m_cnt] = m_cnt; m_em[m_cnt] = m_cnt; m_cnt++;
            end else begin
                req = "R3"; m_ovf = 1; el = 0;
            end
        end else if (c == 2) begin
            req = (lu == 0) ? "R10" : "R4"; ev = 1;
            el = m_tl[m_tl[lu]];
        end else if (c == 3) begin
            req = "R5"; ev = 1;
            tu = m_tl[lu]; tl2 = m_tl[ll];
            mn = (tu < tl2) ? tu : tl2; mx = (tu < tl2) ? tl2 : tu;
            res = m_tl[mn]; oldmax = m_tl[mx];
            emx = m_em[oldmax]; emn = m_em[res];
            el = res;
            if (mx != 0) m_tl[mx] = mn;      // R6
            if (emx != 0) m_em[emx] = emn;   // R7
            if (lu != 0) m_em[lu] = emn;     // R7
        end
        @(negedge clk);
        check({req, " out_valid"}, int'(out_valid), ev);
        if (ev) check({req, " out_label"}, int'(out_label), el);
        check({req, " overflow"}, int'(overflow), int'(m_ovf));
        if (m_cnt > 1) begin
            em_rd_addr = LW'($urandom_range(m_cnt - 1, 1));
            #1;
            check("R7 em_rd_data", int'(em_rd_data), m_em[em_rd_addr]);
        end
        frame_start = 0; cmd = 2'b00;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1500000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NLAB; i++) begin m_tl[i] = 0; m_em[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: the reset state, then the first label issued.
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_label", int'(out_label), 0);
        check("R1 overflow", int'(overflow), 0);
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        step(0, 2, 2, 0);
        step(0, 3, 3, 1);
        step(0, 2, 3, 0);   // R6: the joined label now resolves to 1
        step(0, 3, 4, 2);
        step(0, 2, 4, 0);
        step(0, 3, 2, 4);   // join of labels already in one class
        step(0, 0, 0, 0);   // R9
        step(0, 2, 0, 0);   // R10
        step(0, 3, 0, 2);   // R10: a zero neighbour in a join
        step(1, 1, 0, 0);   // R8: command in the frame-start cycle is ignored
        for (int k = 0; k < NLAB + 2; k++) step(0, 1, 0, 0);  // R3: exhaust the labels
        step(0, 2, 5, 0);
        step(0, 0, 0, 0);
        step(1, 0, 0, 0);   // R8: clears the overflow flag
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(99);
            if (r < 2) step(1, $urandom_range(3), 0, 0);
            else if (m_cnt == 1 || r < 30) step(0, 1, 0, 0);
            else if (r < 35) step(0, 0, 0, 0);
            else if (r < 65) step(0, 2, $urandom_range(m_cnt - 1 < NLAB - 1 ? m_cnt - 1 : NLAB - 1, 1), 0);
            else step(0, 3, $urandom_range(m_cnt - 1 < NLAB - 1 ? m_cnt - 1 : NLAB - 1, 1),
                            $urandom_range(m_cnt - 1 < NLAB - 1 ? m_cnt - 1 : NLAB - 1, 1));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule